// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block sits behind a MAC receive path and stores incoming frames in memory through a ring of descriptors. Each descriptor is two 32-bit words at `ring_base + 8*index`. The first word holds a buffer address, a wrap flag and an ownership flag. The second word holds status. Every buffer holds exactly 128 bytes. A frame longer than one buffer is continued in the next descriptor, and it may wrap from the last ring entry back to entry 0.

Bytes arrive one per cycle at most, with no backpressure. They are packed into 32-bit little-endian words and written through a write port. When a buffer is closed, the block writes its status word and then marks the descriptor as filled. Software hands buffers back by clearing the ownership bit. Descriptor address words are polled through a read port that has one cycle of latency. Frames must be separated by at least two idle cycles, so that the polled word of the next descriptor is current.

The address-filter results for a frame (broadcast, four specific-address hits, type-ID hit) are presented with the frame's last byte. They are recorded in the status of the buffer that ends the frame.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset, no write is issued and the overrun pulse is low until a frame arrives.
- R2: Byte k of a buffer goes to lane k mod 4 of the word at the buffer address (address word with bits 1:0 cleared) plus 4*floor(k/4). A partial final word carries byte enables only for its filled lanes, and its unfilled lanes are zero.
- R3: A buffer holds 128 bytes. Byte 129 of a frame and the bytes after it continue in the next descriptor.
- R4: In the status word, bit 14 is set only in the first buffer of a frame, and bit 15 only in the buffer that ends it. Bits 11:0 hold the total frame length in that last buffer and are zero in every other buffer.
- R5: In the last buffer's status, bit 31 records broadcast, bits 26, 25, 24 and 23 record hits on specific addresses 1, 2, 3 and 4, and bit 22 records a type-ID hit. These bits are zero in other buffers.
- R6: For each buffer, all data writes come first, then the status write, then a write of the address word with bit 0 set and all other bits unchanged.
- R7: A descriptor whose address word has bit 1 set is followed by descriptor 0.
- R8: If the descriptor at which a frame would start has bit 0 set, the whole frame is discarded without any write, and the overrun output pulses for one cycle.
- R9: If the next descriptor still has bit 0 set when a buffer fills mid-frame, the rest of the frame is discarded and overrun pulses. The filled buffer keeps a status without the end flag. The next frame starts at that held descriptor once software clears its bit 0.
- R10: A descriptor whose bit 0 software has cleared is filled again by a later frame.
- R11: A frame of exactly 128 bytes occupies one descriptor, with both the start and end flags set, and the next frame starts in the following descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ring_base | input | 32 | Byte address of descriptor 0 |
| rx_valid | input | 1 | A received byte is present |
| rx_byte | input | 8 | Received byte |
| rx_last | input | 1 | This byte ends the frame |
| rx_bcast | input | 1 | Broadcast destination (with last byte) |
| rx_addr_hit | input | 4 | Specific-address hits 1..4 in bits 0..3 (with last byte) |
| rx_type_hit | input | 1 | Type-ID hit (with last byte) |
| rd_en | output | 1 | Descriptor read request |
| rd_addr | output | 32 | Descriptor read byte address |
| rd_data | input | 32 | Read data, one cycle after the request |
| wr_en | output | 1 | Memory write request |
| wr_addr | output | 32 | Write byte address (word aligned) |
| wr_data | output | 32 | Write data |
| wr_be | output | 4 | Write byte enables |
| overrun | output | 1 | One-cycle pulse when frame data is discarded |

## Verification
A data word appears on the write port in the cycle after the byte that completes it, or after the frame's last byte. The status write and the ownership write of that buffer follow in the next cycles in which the port is not carrying data. An overrun pulse is visible in the cycle after the byte that triggered it. A scoreboard holds the expected writes in issue order and compares each write at the falling clock edge as it appears. A fixed idle window after each frame confirms that every expected write has arrived and that the overrun count matches the model. Frames are sized so that the final buffer of each frame holds at least four bytes. This keeps the issue order fixed: data, status, ownership.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
   localparam int ADDR_W    = 32;
   localparam int WORD_W    = 32;
   localparam int LEN_W     = 12;
   localparam int ST_FIRST  = 14;
   localparam int ST_LAST   = 15;
   localparam int ST_TYPE   = 22;
   localparam int ST_HIT1   = 26;
   localparam int ST_BCAST  = 31;
   localparam int AW_OWNED  = 0;
   localparam int AW_WRAP   = 1;

   typedef enum logic [1:0] {
      S_IDLE = 2'd0,
      S_RECV = 2'd1,
      S_DROP = 2'd2
   } rx_state_e;

   typedef struct packed {
      logic [ADDR_W-1:0] desc_addr;
      logic [WORD_W-1:0] status;
      logic [WORD_W-1:0] own_word;
   } desc_job_t;
endpackage

// File: rtl/rxr_fifo.sv
module rxr_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [W-1:0]  store [DEPTH];
   logic [PW-1:0] wp_q, rp_q;
   logic [PW:0]   cnt_q;

   initial assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
      else $error("rxr_fifo: DEPTH must be a power of two of at least 2");

   assign empty = (cnt_q == '0);
   assign full  = (cnt_q == (PW+1)'(DEPTH));
   assign dout  = store[rp_q];

   always_ff @(posedge clk) begin
      if (rst) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push) begin
            store[wp_q] <= din;
            wp_q        <= wp_q + 1'b1;
         end
         if (pop) rp_q <= rp_q + 1'b1;
         case ({push, pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
      push |-> !full);
   a_r6_no_underflow: assert property (@(posedge clk) disable iff (rst)
      pop |-> !empty);
endmodule

// File: rtl/rxr_pack.sv
module rxr_pack #(
   parameter int LANES = 4
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   take,
   input  logic [$clog2(LANES)-1:0] lane,
   input  logic [7:0]             byte_in,
   output logic [LANES*8-1:0]     word_o,
   output logic [LANES-1:0]       be_o
);
   localparam int LW = $clog2(LANES);

   logic [LANES*8-1:0] acc_q, acc_d;
   logic [LANES-1:0]   be_q, be_d;

   initial assert (LANES >= 2 && (LANES & (LANES - 1)) == 0)
      else $error("rxr_pack: LANES must be a power of two");

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      always_comb begin
         if (lane == LW'(g)) begin
            acc_d[g*8 +: 8] = byte_in;
            be_d[g]         = 1'b1;
         end else if (lane == '0) begin
            acc_d[g*8 +: 8] = 8'h00;
            be_d[g]         = 1'b0;
         end else begin
            acc_d[g*8 +: 8] = acc_q[g*8 +: 8];
            be_d[g]         = be_q[g];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_q <= '0;
         be_q  <= '0;
      end else if (take) begin
         acc_q <= acc_d;
         be_q  <= be_d;
      end
   end

   assign word_o = acc_d;
   assign be_o   = be_d;

   a_r2_lane_mark: assert property (@(posedge clk) disable iff (rst)
      take |-> be_o[lane]);
endmodule

// File: rtl/rxr_wport.sv
module rxr_wport
   import rxr_pkg::*;
(
   input  logic              clk,
   input  logic              rst,
   input  logic              data_req,
   input  logic [ADDR_W-1:0] data_addr,
   input  logic [WORD_W-1:0] data_word,
   input  logic [3:0]        data_be,
   input  logic              job_vld,
   input  desc_job_t         job,
   output logic              job_pop,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [WORD_W-1:0] wr_data,
   output logic [3:0]        wr_be
);
   logic owner_phase_q;

   assign job_pop = !data_req && job_vld && owner_phase_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_en         <= 1'b0;
         wr_addr       <= '0;
         wr_data       <= '0;
         wr_be         <= '0;
         owner_phase_q <= 1'b0;
      end else if (data_req) begin
         wr_en   <= 1'b1;
         wr_addr <= data_addr;
         wr_data <= data_word;
         wr_be   <= data_be;
      end else if (job_vld) begin
         wr_en         <= 1'b1;
         wr_be         <= 4'hF;
         owner_phase_q <= !owner_phase_q;
         if (owner_phase_q) begin
            wr_addr <= job.desc_addr;
            wr_data <= job.own_word;
         end else begin
            wr_addr <= job.desc_addr + ADDR_W'(4);
            wr_data <= job.status;
         end
      end else begin
         wr_en <= 1'b0;
      end
   end

   a_r6_data_priority: assert property (@(posedge clk) disable iff (rst)
      data_req |=> (wr_en && wr_addr == $past(data_addr) && wr_be == $past(data_be)));
   a_r2_be_contiguous: assert property (@(posedge clk) disable iff (rst)
      wr_en |-> (wr_be inside {4'h1, 4'h3, 4'h7, 4'hF}));
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
   import rxr_pkg::*;
#(
   parameter int IDX_W      = 8,
   parameter int SLOT_BYTES = 128,
   parameter int JOBQ_DEPTH = 4
) (
   input  logic        clk,
   input  logic        rst,
   input  logic [31:0] ring_base,
   input  logic        rx_valid,
   input  logic [7:0]  rx_byte,
   input  logic        rx_last,
   input  logic        rx_bcast,
   input  logic [3:0]  rx_addr_hit,
   input  logic        rx_type_hit,
   output logic        rd_en,
   output logic [31:0] rd_addr,
   input  logic [31:0] rd_data,
   output logic        wr_en,
   output logic [31:0] wr_addr,
   output logic [31:0] wr_data,
   output logic [3:0]  wr_be,
   output logic        overrun
);
   localparam int OFF_W  = $clog2(SLOT_BYTES);
   localparam int LANES  = WORD_W / 8;
   localparam int LANE_W = $clog2(LANES);

   initial assert (IDX_W >= 1 && IDX_W <= ADDR_W - 3)
      else $error("rx_ring_writer: IDX_W out of range");
   initial assert (SLOT_BYTES >= 2*LANES && (SLOT_BYTES & (SLOT_BYTES - 1)) == 0)
      else $error("rx_ring_writer: SLOT_BYTES must be a power of two");
   initial assert (SLOT_BYTES < (1 << LEN_W))
      else $error("rx_ring_writer: SLOT_BYTES exceeds length field");

   rx_state_e         state_q;
   logic [IDX_W-1:0]  cur_idx_q, nxt_idx, poll_idx, tag_idx_q;
   logic [WORD_W-1:0] cur_word_q, nxt_word_q;
   logic              cur_vld_q, nxt_vld_q, tag_vld_q, tag_nxt_q;
   logic [OFF_W-1:0]  off_q;
   logic              first_q;
   logic [LEN_W-1:0]  flen_q, flen_d;
   logic              ovr_q;

   logic              start_ok, adv_ok, take, slot_full, slot_end, emit;
   logic [ADDR_W-1:0] data_addr;
   logic [WORD_W-1:0] pack_word;
   logic [LANES-1:0]  pack_be;
   desc_job_t         job_new, job_head;
   logic              job_empty, job_full, job_pop;

   function automatic logic [ADDR_W-1:0] desc_at(input logic [ADDR_W-1:0] base,
                                                 input logic [IDX_W-1:0] idx);
      return base + {{(ADDR_W-IDX_W-3){1'b0}}, idx, 3'b000};
   endfunction

   // ring walk and polling
   assign nxt_idx  = cur_word_q[AW_WRAP] ? '0 : cur_idx_q + 1'b1;
   assign poll_idx = (state_q == S_RECV) ? nxt_idx : cur_idx_q;
   assign rd_en    = !rst;
   assign rd_addr  = desc_at(ring_base, poll_idx);

   assign start_ok  = cur_vld_q && !cur_word_q[AW_OWNED];
   assign adv_ok    = nxt_vld_q && !nxt_word_q[AW_OWNED];
   assign take      = rx_valid && ((state_q == S_RECV) ||
                                   (state_q == S_IDLE && start_ok));
   assign slot_full = &off_q;
   assign slot_end  = take && (rx_last || slot_full);
   assign emit      = take && ((off_q[LANE_W-1:0] == '1) || rx_last);
   assign flen_d    = flen_q + 1'b1;

   assign data_addr = {cur_word_q[ADDR_W-1:2], 2'b00} +
                      {{(ADDR_W-OFF_W){1'b0}}, off_q[OFF_W-1:LANE_W], {LANE_W{1'b0}}};

   // descriptor closing job
   always_comb begin
      job_new           = '0;
      job_new.desc_addr = desc_at(ring_base, cur_idx_q);
      job_new.own_word  = cur_word_q | WORD_W'(1 << AW_OWNED);
      job_new.status[ST_FIRST] = first_q;
      if (rx_last) begin
         job_new.status[ST_LAST]      = 1'b1;
         job_new.status[LEN_W-1:0]    = flen_d;
         job_new.status[ST_BCAST]     = rx_bcast;
         job_new.status[ST_TYPE]      = rx_type_hit;
         for (int h = 0; h < 4; h++)
            job_new.status[ST_HIT1-h] = rx_addr_hit[h];
      end
   end

   rxr_pack #(.LANES(LANES)) u_pack (
      .clk     (clk),
      .rst     (rst),
      .take    (take),
      .lane    (off_q[LANE_W-1:0]),
      .byte_in (rx_byte),
      .word_o  (pack_word),
      .be_o    (pack_be)
   );

   rxr_fifo #(.W($bits(desc_job_t)), .DEPTH(JOBQ_DEPTH)) u_jobq (
      .clk   (clk),
      .rst   (rst),
      .push  (slot_end),
      .din   (job_new),
      .pop   (job_pop),
      .dout  (job_head),
      .empty (job_empty),
      .full  (job_full)
   );

   rxr_wport u_wport (
      .clk       (clk),
      .rst       (rst),
      .data_req  (emit),
      .data_addr (data_addr),
      .data_word (pack_word),
      .data_be   (pack_be),
      .job_vld   (!job_empty),
      .job       (job_head),
      .job_pop   (job_pop),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .wr_be     (wr_be)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q    <= S_IDLE;
         cur_idx_q  <= '0;
         cur_word_q <= '0;
         cur_vld_q  <= 1'b0;
         nxt_word_q <= '0;
         nxt_vld_q  <= 1'b0;
         tag_vld_q  <= 1'b0;
         tag_nxt_q  <= 1'b0;
         tag_idx_q  <= '0;
         off_q      <= '0;
         first_q    <= 1'b1;
         flen_q     <= '0;
         ovr_q      <= 1'b0;
      end else begin
         ovr_q     <= 1'b0;
         tag_vld_q <= 1'b1;
         tag_nxt_q <= (state_q == S_RECV);
         tag_idx_q <= poll_idx;

         // capture polled descriptor words
         if (tag_vld_q && tag_nxt_q && state_q == S_RECV && tag_idx_q == nxt_idx) begin
            nxt_word_q <= rd_data;
            nxt_vld_q  <= 1'b1;
         end
         if (tag_vld_q && !tag_nxt_q && state_q != S_RECV && tag_idx_q == cur_idx_q) begin
            cur_word_q <= rd_data;
            cur_vld_q  <= 1'b1;
         end

         if (take) begin
            off_q   <= off_q + 1'b1;
            flen_q  <= flen_d;
            state_q <= S_RECV;
            if (slot_end) begin
               cur_idx_q <= nxt_idx;
               nxt_vld_q <= 1'b0;
               off_q     <= '0;
               if (rx_last) begin
                  state_q   <= S_IDLE;
                  cur_vld_q <= 1'b0;
                  first_q   <= 1'b1;
                  flen_q    <= '0;
               end else if (adv_ok) begin
                  cur_word_q <= nxt_word_q;
                  cur_vld_q  <= 1'b1;
                  first_q    <= 1'b0;
               end else begin
                  state_q   <= S_DROP;
                  ovr_q     <= 1'b1;
                  cur_vld_q <= 1'b0;
                  first_q   <= 1'b1;
                  flen_q    <= '0;
               end
            end
         end else if (rx_valid) begin
            if (state_q == S_IDLE) begin
               ovr_q <= 1'b1;
               if (!rx_last) state_q <= S_DROP;
            end else if (state_q == S_DROP && rx_last) begin
               state_q <= S_IDLE;
            end
         end
      end
   end

   assign overrun = ovr_q;

   a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!wr_en && !overrun));
   a_r7_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
      (slot_end && cur_word_q[AW_WRAP]) |=> (cur_idx_q == '0));
   a_r3_next_slot: assert property (@(posedge clk) disable iff (rst)
      (take && slot_full && !rx_last && adv_ok) |=> (off_q == '0 && state_q == S_RECV && !first_q));
   a_r9_overrun_not_storing: assert property (@(posedge clk) disable iff (rst)
      overrun |-> (state_q != S_RECV));
   a_r6_job_room: assert property (@(posedge clk) disable iff (rst)
      slot_end |-> !job_full);
endmodule

// File: tb/rx_ring_writer_tb.sv
`timescale 1ns/1ps
module rx_ring_writer_tb;
   localparam int NDESC = 4;
   localparam logic [31:0] BUF0 = 32'h100;

   typedef struct {
      logic [31:0] a;
      logic [31:0] d;
      logic [3:0]  be;
      string       tag;
   } wr_t;

   logic        clk = 1'b0;
   logic        rst;
   logic        rx_valid, rx_last, rx_bcast, rx_type_hit;
   logic [7:0]  rx_byte;
   logic [3:0]  rx_addr_hit;
   logic        rd_en, wr_en, overrun;
   logic [31:0] rd_addr, rd_data, wr_addr, wr_data;
   logic [3:0]  wr_be;

   logic [31:0] mem [256];
   wr_t         expq [$];
   bit          own [NDESC];
   int          m_cur = 0;
   int          checks = 0, fails = 0;
   int          ovr_seen = 0, exp_ovr = 0;

   always #2 clk = ~clk;

   rx_ring_writer u_dut (
      .clk(clk), .rst(rst), .ring_base(32'h0),
      .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_last(rx_last),
      .rx_bcast(rx_bcast), .rx_addr_hit(rx_addr_hit), .rx_type_hit(rx_type_hit),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
      .overrun(overrun)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] bval(input int seed, input int k);
      return 8'((k * 7 + seed * 13 + 1) & 255);
   endfunction

   function automatic logic [31:0] addr_word(input int i);
      return BUF0 + 32'(i * 128) | ((i == NDESC - 1) ? 32'h2 : 32'h0);
   endfunction

   // memory model: registered read, writes applied from the monitor
   always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr[9:2]];

   // monitor / scoreboard
   always @(negedge clk) begin
      if (!rst) begin
         if (overrun) ovr_seen++;
         if (wr_en) begin
            if (expq.size() == 0) begin
               chk(1'b0, "R6 unexpected write", wr_addr, 32'hFFFF_FFFF);
            end else begin
               wr_t e;
               e = expq.pop_front();
               chk(wr_addr == e.a, {e.tag, " address"}, wr_addr, e.a);
               chk(wr_data == e.d && wr_be == e.be, {e.tag, " data"}, wr_data, e.d);
            end
            for (int l = 0; l < 4; l++)
               if (wr_be[l]) mem[wr_addr[9:2]][l*8 +: 8] = wr_data[l*8 +: 8];
         end
      end
   end

   task automatic free_desc(input int i);
      @(negedge clk);
      mem[2*i][0] = 1'b0;
      own[i] = 1'b0;
   endtask

   task automatic send_frame(input int len, input int seed, input logic bc,
                             input logic [3:0] hit, input logic ty, input string tag);
      int idx, pos, n, nidx;
      bit first, last;
      logic [31:0] st, w;
      logic [3:0] be;
      idx = m_cur;
      if (own[idx]) begin
         exp_ovr++;
      end else begin
         pos = 0;
         first = 1;
         forever begin
            n = (len - pos > 128) ? 128 : len - pos;
            last = (pos + n == len);
            for (int wi = 0; wi < (n + 3) / 4; wi++) begin
               w = 0; be = 0;
               for (int l = 0; l < 4; l++) begin
                  if (wi*4 + l < n) begin
                     w[l*8 +: 8] = bval(seed, pos + wi*4 + l);
                     be[l] = 1'b1;
                  end
               end
               expq.push_back('{BUF0 + 32'(idx*128 + wi*4), w, be, first ? "R2" : "R3"});
            end
            st = 0;
            st[14] = first;
            if (last) begin
               st[15] = 1'b1;
               st[11:0] = 12'(len);
               st[31] = bc;
               st[26] = hit[0]; st[25] = hit[1]; st[24] = hit[2]; st[23] = hit[3];
               st[22] = ty;
            end
            expq.push_back('{32'(idx*8 + 4), st, 4'hF, last ? "R4 R5" : "R4"});
            expq.push_back('{32'(idx*8), addr_word(idx) | 32'h1, 4'hF,
                             (idx == NDESC - 1) ? "R7" : "R6"});
            own[idx] = 1'b1;
            pos += n;
            first = 0;
            nidx = (idx == NDESC - 1) ? 0 : idx + 1;
            if (last) begin
               m_cur = nidx;
               break;
            end else if (own[nidx]) begin
               exp_ovr++;
               m_cur = nidx;
               break;
            end
            idx = nidx;
         end
      end
      for (int k = 0; k < len; k++) begin
         @(negedge clk);
         rx_valid = 1'b1;
         rx_byte = bval(seed, k);
         rx_last = (k == len - 1);
         rx_bcast = bc; rx_addr_hit = hit; rx_type_hit = ty;
      end
      @(negedge clk);
      rx_valid = 1'b0; rx_last = 1'b0;
      rx_bcast = 1'b0; rx_addr_hit = 4'h0; rx_type_hit = 1'b0;
      repeat (12) @(negedge clk);
      chk(expq.size() == 0, {tag, " all writes seen"}, 32'(expq.size()), 32'h0);
      chk(ovr_seen == exp_ovr, {tag, " overrun count"}, 32'(ovr_seen), 32'(exp_ovr));
   endtask

   initial begin
      rst = 1'b1;
      rx_valid = 1'b0; rx_byte = 8'h0; rx_last = 1'b0;
      rx_bcast = 1'b0; rx_addr_hit = 4'h0; rx_type_hit = 1'b0;
      for (int i = 0; i < 256; i++) mem[i] = 32'h0;
      for (int i = 0; i < NDESC; i++) begin
         mem[2*i] = addr_word(i);
         own[i] = 1'b0;
      end
      repeat (5) @(negedge clk);
      rst = 1'b0;
      for (int c = 0; c < 6; c++) begin
         @(negedge clk);
         chk(!wr_en && !overrun, "R1 idle after reset", {30'h0, wr_en, overrun}, 32'h0);
      end
      send_frame(61, 1, 1'b1, 4'h0, 1'b0, "R2");      // d0, partial last word
      send_frame(200, 2, 1'b0, 4'h5, 1'b1, "R3");     // d1 -> d2
      free_desc(0); free_desc(1); free_desc(2);
      repeat (5) @(negedge clk);
      send_frame(302, 3, 1'b0, 4'hA, 1'b0, "R7");     // d3 -> d0 -> d1 wrap
      send_frame(200, 4, 1'b1, 4'h0, 1'b0, "R9");     // d2, then d3 held
      send_frame(20, 5, 1'b0, 4'h1, 1'b0, "R8");      // d3 held: all dropped
      free_desc(3);
      repeat (5) @(negedge clk);
      send_frame(128, 6, 1'b1, 4'hF, 1'b1, "R11");    // exact one slot in d3
      free_desc(0); free_desc(1); free_desc(2);
      repeat (5) @(negedge clk);
      send_frame(63, 7, 1'b1, 4'h2, 1'b0, "R10");     // reused d0
      chk(mem[0] == (addr_word(0) | 32'h1), "R10 owner in memory", mem[0], addr_word(0) | 32'h1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule